// File: doc/BRIEF.md
# Read-Only I2C Status Responder

This block is an I2C target that answers read transfers only. It decodes a 7-bit address whose upper five bits are fixed at `11000` and whose two lowest bits come from strap inputs, so up to four of these responders can share one bus. When it sees its own address with the read bit set, it acknowledges. It then shifts out a status byte, most significant bit first. The byte carries a power-on flag, a lock flag and a 3-bit level code.

The controller can read the byte as often as it likes: each acknowledge from the controller makes the responder send the same status again. A not-acknowledge ends the transfer. The responder then releases the data line so the controller can issue a STOP, and the power-on flag is cleared.

Both bus lines are oversampled on the system clock. SDA is driven open-drain, through a pull-low enable and a separate input sense.

Top module: `stat_rd_slave`

## Requirements
- R1: When bits `1,1,0,0,0,sel[1],sel[0],1` (sent MSB first) follow a START, the block drives SDA low through the whole ninth SCL clock.
- R2: If the address bits differ from `1,1,0,0,0,sel[1],sel[0]`, or the R/W bit is 0, the block does not acknowledge. It then leaves SDA released until the next START.
- R3: The status byte is sent MSB first with this layout: bit 7 is the power-on flag, bit 6 is the lock input (1 = locked), bits 5..3 are 1, and bits 2..0 are the level code.
- R4: The block changes its SDA drive only while SCL is low, so each data bit is stable for the whole SCL high phase.
- R5: After each controller acknowledge (SDA low on the ninth clock), the block sends the status byte again. The number of repeats has no limit.
- R6: After a controller not-acknowledge (SDA high on the ninth clock), the block releases SDA and drives no further bits.
- R7: The power-on flag is 1 after reset and while the low-supply input is high. A read that ends with a not-acknowledge clears it. If the low-supply input and a clear occur together, the flag stays set.
- R8: The level code is taken from a 4-bit thermometer input whose bit 0 is the lowest comparator. The input values map to codes as follows: 0000→000, 0001→001, 0011→010, 0111→011, 1111→100.
- R9: The status byte is captured at the start of each byte. An input change during a byte appears only in the next byte.
- R10: A START or a STOP at any point returns the receiver to address matching. A STOP also leaves the block idle until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock sense |
| sda_i | input | 1 | Bus data sense |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Lock indicator |
| low_supply_i | input | 1 | Low-supply detect, sets power-on flag |
| lvl_thermo_i | input | 4 | Thermometer comparator outputs |

## Verification
The bench tries every combination of the four strap settings, the four values of the address low bits and both R/W values. Only matching reads may be acknowledged, and after a rejected address the line must stay quiet for the following clocks. Each of the five thermometer levels is paired with both lock states, so a mistake in the level code cannot hide behind a fixed bit pattern in the byte. Reads of one, two and five bytes separate the repeat-on-acknowledge path from the release-on-not-acknowledge path. Further cases cover:
- a level change in the middle of a byte, which must reach only the following byte;
- the low-supply input held high across a clear;
- a repeated START and a STOP in the middle of an address.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AWAIT,
    ST_LOAD,
    ST_TX,
    ST_MACK
  } rd_state_e;

  localparam logic [4:0] ADDR_FIXED = 5'b11000;
  localparam int STATUS_W = 8;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg      <= {STAGES{RST_VAL}};
      q_prev_o <= RST_VAL;
    end else begin
      stg      <= {stg[STAGES-2:0], d_i};
      q_prev_o <= stg[STAGES-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lvl_encode.sv
module lvl_encode #(
  parameter int LVL_W  = 4,
  parameter int CODE_W = 3
) (
  input  logic [LVL_W-1:0]  thermo_i,
  output logic [CODE_W-1:0] code_o
);
  // highest set comparator wins; equals the count for a clean thermometer
  always_comb begin
    code_o = '0;
    for (int i = 0; i < LVL_W; i++) begin
      if (thermo_i[i]) code_o = CODE_W'(i + 1);
    end
  end

  always_comb begin
    p_code_range_r8: assert (code_o <= CODE_W'(LVL_W));
    if (thermo_i == '0) p_code_zero_r8: assert (code_o == '0);
  end
endmodule

// File: rtl/pof_reg.sv
module pof_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pof_o
);
  always_ff @(posedge clk) begin
    if (rst || set_i) pof_o <= 1'b1;
    else if (clr_i)   pof_o <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pof_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pof_o);
endmodule

// File: rtl/rd_engine.sv
module rd_engine
  import srs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                scl_prev_i,
  input  logic                sda_i,
  input  logic                sda_prev_i,
  input  logic [1:0]          sel_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                sda_oe_o,
  output logic                rd_done_o
);
  rd_state_e           st;
  logic [2:0]          cnt;
  logic [STATUS_W-1:0] sh;
  logic [STATUS_W-1:0] addr_byte;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise  = scl_i & ~scl_prev_i;
  assign scl_fall  = ~scl_i & scl_prev_i;
  assign start_c   = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  assign stop_c    = scl_i & scl_prev_i & ~sda_prev_i & sda_i;
  assign addr_byte = {sh[STATUS_W-2:0], sda_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      sda_oe_o  <= 1'b0;
      rd_done_o <= 1'b0;
    end else begin
      rd_done_o <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            sh <= addr_byte;
            if (cnt == 3'd7) begin
              cnt <= '0;
              st  <= (addr_byte == {ADDR_FIXED, sel_i, 1'b1}) ? ST_AWAIT : ST_IDLE;
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          ST_AWAIT: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            st       <= ST_LOAD;
          end
          ST_LOAD: if (scl_fall) begin
            sh       <= {status_i[STATUS_W-2:0], 1'b0};
            sda_oe_o <= ~status_i[STATUS_W-1];
            cnt      <= '0;
            st       <= ST_TX;
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              st       <= ST_MACK;
            end else begin
              sda_oe_o <= ~sh[STATUS_W-1];
              sh       <= {sh[STATUS_W-2:0], 1'b0};
              cnt      <= cnt + 3'd1;
            end
          end
          ST_MACK: if (scl_rise) begin
            if (sda_i) begin
              st        <= ST_IDLE;
              rd_done_o <= 1'b1;
            end else begin
              st <= ST_LOAD;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_c || stop_c));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe_o);
  p_mack_release_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK) |-> !sda_oe_o);
  p_nack_end_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK && scl_rise && sda_i && !start_c && !stop_c)
      |=> (st == ST_IDLE && !sda_oe_o && rd_done_o));
endmodule

// File: rtl/stat_rd_slave.sv
module stat_rd_slave
  import srs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 4,
  parameter int CODE_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic             lock_i,
  input  logic             low_supply_i,
  input  logic [LVL_W-1:0] lvl_thermo_i
);
  localparam int FILL_W = STATUS_W - 2 - CODE_W;

  logic [2:0] pins_q, pins_prev;
  logic [CODE_W-1:0] code;
  logic pof, rd_done;
  logic [STATUS_W-1:0] status;

  pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({low_supply_i, sda_i, scl_i}),
    .q_o(pins_q), .q_prev_o(pins_prev)
  );

  lvl_encode #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_enc (
    .thermo_i(lvl_thermo_i), .code_o(code)
  );

  pof_reg u_pof (
    .clk(clk), .rst(rst), .set_i(pins_q[2]), .clr_i(rd_done), .pof_o(pof)
  );

  assign status = {pof, lock_i, {FILL_W{1'b1}}, code};

  rd_engine u_eng (
    .clk(clk), .rst(rst),
    .scl_i(pins_q[0]), .scl_prev_i(pins_prev[0]),
    .sda_i(pins_q[1]), .sda_prev_i(pins_prev[1]),
    .sel_i(addr_sel_i), .status_i(status),
    .sda_oe_o(sda_oe_o), .rd_done_o(rd_done)
  );
endmodule

// File: tb/stat_rd_slave_tb.sv
module stat_rd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl = 1'b1, m_low = 1'b0, sda_oe;
  logic [1:0] sel = 2'd0;
  logic lock = 1'b0, lowv = 1'b0;
  logic [3:0] lvl = 4'd0;
  wire sda_bus = ~(m_low | sda_oe);

  int checks = 0, errors = 0;
  bit pof_exp = 1'b1;
  bit finished = 1'b0;

  stat_rd_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .lock_i(lock), .low_supply_i(lowv), .lvl_thermo_i(lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_stat(input bit p, input bit lk, input logic [3:0] th);
    int n = 0;
    for (int i = 0; i < 4; i++) n += th[i];
    return {p, lk, 3'b111, 3'(n)};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; wt(QTR);
    m_scl = 1'b1; wt(QTR);
    m_low = 1'b1; wt(QTR);
    m_scl = 1'b0; wt(QTR);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(QTR);
    m_scl = 1'b1; wt(QTR);
    m_low = 1'b0; wt(QTR);
  endtask

  task automatic send_bit(input bit b);
    m_low = ~b; wt(QTR);
    m_scl = 1'b1; wt(2*QTR);
    m_scl = 1'b0; wt(QTR);
  endtask

  task automatic recv_bit(output bit b, output bit stab);
    bit b1, b2;
    m_low = 1'b0; wt(QTR);
    m_scl = 1'b1; wt(QTR);
    b1 = sda_bus; wt(QTR);
    b2 = sda_bus;
    m_scl = 1'b0; wt(QTR);
    b = b1; stab = (b1 == b2);
  endtask

  task automatic read_seq(input logic [7:0] a, input bit exp_ack, input int n, input int flip_at);
    bit b, s, acked, stab;
    logic [7:0] d, e;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    recv_bit(b, s);
    acked = ~b;
    chk(acked == exp_ack, exp_ack ? "R1 ack" : "R2 no ack", acked, exp_ack);
    if (!acked) begin
      bit quiet = 1'b1;
      for (int i = 0; i < 9; i++) begin recv_bit(b, s); quiet &= b; end
      chk(quiet, "R2 line quiet after reject", quiet, 1);
    end else begin
      for (int k = 0; k < n; k++) begin
        e = exp_stat(pof_exp, lock, lvl);
        stab = 1'b1;
        for (int i = 0; i < 8; i++) begin
          if (k == 0 && i == flip_at) lvl = 4'b1111;
          recv_bit(b, s);
          d[7-i] = b;
          stab &= s;
        end
        chk(d == e, "R3 R5 R8 R9 status byte", d, e);
        chk(stab, "R4 stable during SCL high", stab, 1);
        if (k < n-1) send_bit(1'b0);
        else begin
          bit drv = 1'b0;
          send_bit(1'b1);
          for (int i = 0; i < 2*QTR; i++) begin drv |= sda_oe; wt(1); end
          chk(!drv, "R6 released after nack", drv, 0);
        end
      end
      pof_exp = lowv;
    end
    bus_stop();
    wt(2*QTR);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(4);
    chk(sda_oe == 1'b0, "R2 reset idle", sda_oe, 0);

    // R7: flag set after reset, cleared by first completed read
    read_seq(8'hC1, 1'b1, 1, -1);
    read_seq(8'hC1, 1'b1, 1, -1);

    // R8 R3: level sweep with both lock values
    for (int k = 0; k <= 4; k++) begin
      for (int l = 0; l < 2; l++) begin
        lvl = 4'((1 << k) - 1);
        lock = l[0];
        read_seq(8'hC1, 1'b1, 2, -1);
      end
    end

    // R5: long repeated read
    lvl = 4'b0011; lock = 1'b1;
    read_seq(8'hC1, 1'b1, 5, -1);

    // R1 R2: address and R/W sweep
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int lo = 0; lo < 4; lo++) begin
        for (int rw = 0; rw < 2; rw++) begin
          read_seq({5'b11000, 2'(lo), 1'(rw)}, (lo == s) && (rw == 1), 1, -1);
        end
      end
    end
    sel = 2'd0;
    read_seq(8'h41, 1'b0, 1, -1);
    read_seq(8'hE1, 1'b0, 1, -1);

    // R7: low-supply pulse, then held across a clear
    lowv = 1'b1; wt(10); lowv = 1'b0; wt(10);
    pof_exp = 1'b1;
    read_seq(8'hC1, 1'b1, 2, -1);
    read_seq(8'hC1, 1'b1, 1, -1);
    lowv = 1'b1; wt(10); pof_exp = 1'b1;
    read_seq(8'hC1, 1'b1, 1, -1);
    lowv = 1'b0; wt(10);
    read_seq(8'hC1, 1'b1, 1, -1);
    read_seq(8'hC1, 1'b1, 1, -1);

    // R9: level change mid-byte reaches only the next byte
    lvl = 4'b0000; lock = 1'b0;
    read_seq(8'hC1, 1'b1, 2, 3);

    // R10: repeated START mid-address restarts matching
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    read_seq(8'hC1, 1'b1, 1, -1);

    // R10: STOP mid-address, then bits without START are ignored
    begin
      bit b, s;
      logic [7:0] a = 8'hC1;
      bus_start();
      send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      m_low = 1'b0; wt(QTR);
      m_scl = 1'b0; wt(QTR);
      for (int i = 7; i >= 0; i--) send_bit(a[i]);
      recv_bit(b, s);
      chk(b == 1'b1, "R10 no ack after STOP", b, 1);
      bus_stop();
      wt(2*QTR);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule